// File: doc/BRIEF.md
# Programmable Countdown Timer with Sticky Flags

The block counts down a software-programmed period value once per tick of a chosen time base. It signals each period end by setting a sticky timer flag and, when enabled, by raising an interrupt. Four tick strobes come in from an external prescaler, nominally 4.096 kHz, 64 Hz, 1 Hz and one per minute. A 2-bit source field picks which strobe drives the counter. Each strobe is high for exactly one system clock cycle, so the whole block runs in a single clock domain.

A small synchronous register bus gives access to a control register, the reload value, the live count and a flag register. The flag register holds the timer flag and two event flags, alarm and minute/second, which are set from their own inputs. Software clears a flag by writing 0 to its bit. Writing 1 keeps the current value, so one flag can be cleared without disturbing the others. The interrupt output either pulses for one cycle at every period end or follows the timer flag as a level.

Top module: `cd_timer`

## Requirements
- R1: After reset, the control, reload, count and flag registers all read 0 and irq_o is low.
- R2: Only the strobe `tick_i[src]` advances the counter, where `src` is control bits 2:1 (0 = 4.096 kHz, 1 = 64 Hz, 2 = 1 Hz, 3 = 1/60 Hz). Strobes on the other three inputs have no effect on the count.
- R3: Control bit 0 is the run bit. A write that takes it from 0 to 1 arms a load: the next selected tick copies the reload value (address 1) into the counter. Each later tick decrements the count. A tick that finds the count at 1 (or 0) ends the period and reloads the stored value. A write that leaves the run bit at 1 does not re-arm the load.
- R4: Every period end sets the timer flag (flag register bit 0) at the clock edge that samples the ending tick. The flag then stays set until software clears it.
- R5: A write to the flag register (address 3) replaces each flag with its current value ANDed with the written bit. Bit 0 is the timer flag, bit 1 the alarm flag and bit 2 the minute/second flag. Writing 1 to a bit leaves that flag unchanged.
- R6: If an event sets a flag in the same cycle that a write clears it, the flag ends up set.
- R7: A one-cycle pulse on alarm_evt_i sets the alarm flag, and a pulse on ms_evt_i sets the minute/second flag. No flag is ever set without its event.
- R8: When the interrupt-enable bit (control bit 3) is 1 and the pulse-mode bit (control bit 4) is 0, irq_o equals the timer flag.
- R9: When the interrupt-enable bit and the pulse-mode bit are both 1, irq_o goes high for exactly one cycle at every period end, in the same cycle the timer flag becomes set. This happens even if the flag was already set.
- R10: When the interrupt-enable bit is 0, irq_o stays low in both modes, but the timer flag is still set at each period end.
- R11: Reading address 2 returns the live count. Writes to address 2 are ignored.
- R12: A new reload value written while the timer runs does not change the period in progress. It is used at the next reload.
- R13: While the run bit is 0, the count holds its value and no period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 4 | One-cycle tick strobes, index = source code |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 control, 1 reload, 2 count, 3 flags) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| alarm_evt_i | input | 1 | Alarm event pulse, sets alarm flag |
| ms_evt_i | input | 1 | Minute/second event pulse, sets its flag |
| irq_o | output | 1 | Timer interrupt, active high |

## Verification
The bench drives every input on a falling edge. Register writes, count updates, flag sets and the interrupt pulse all take effect at the next rising edge, so each one is checked on the falling edge that follows it. Readback is a combinational mux, so it is sampled a short delay after the address settles, with no clock in between. The one-cycle pulse gets one more check a full cycle later to confirm it has dropped. The period-end cases are counted tick by tick against the programmed value, including a reload change made in the middle of a period.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_COUNT  = 2'd2,
    ADDR_FLAGS  = 2'd3
  } addr_e;

  typedef struct packed {
    logic       pulse_mode;
    logic       irq_en;
    logic [1:0] src;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int N_FLAGS = 3;
  localparam int FLAG_TMR = 0;
  localparam int FLAG_ALM = 1;
  localparam int FLAG_MS  = 2;
endpackage

// File: rtl/cdt_tick_sel.sv
module cdt_tick_sel #(
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [N_SRC-1:0] hit;
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g));
  end
  assign tick_o = |hit;
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             end_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             arm_q;
  logic             at_last;
  logic             adv;

  assign adv     = run_i && tick_i;
  assign at_last = (cnt_q == '0) || (cnt_q == CNT_W'(1));
  assign end_o   = adv && !arm_q && at_last;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else begin
      if (start_i)      arm_q <= 1'b1;
      else if (!run_i)  arm_q <= 1'b0;
      else if (tick_i)  arm_q <= 1'b0;
      if (adv) begin
        if (arm_q || at_last) cnt_q <= reload_i;
        else                  cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cdt_flags.sv
module cdt_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] kept;

  // write-AND, event set wins over same-cycle clear
  assign kept    = wr_i ? (flags_q & wdata_i) : flags_q;
  assign flags_o = flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= kept | set_i;
  end
endmodule

// File: rtl/cd_timer.sv
module cd_timer #(
  parameter int N_SRC  = 4,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              alarm_evt_i,
  input  logic              ms_evt_i,
  output logic              irq_o
);
  import cdt_pkg::*;

  ctrl_t                ctrl_q;
  ctrl_t                ctrl_wr;
  logic [CNT_W-1:0]     reload_q;
  logic [CNT_W-1:0]     count;
  logic [N_FLAGS-1:0]   flags_q;
  logic [N_FLAGS-1:0]   flag_set;
  logic                 sel_tick;
  logic                 period_end;
  logic                 pulse_q;
  logic                 start;
  logic                 we_ctrl, we_reload, we_flags;

  assign we_ctrl   = we_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign we_reload = we_i && (addr_i == ADDR_W'(ADDR_RELOAD));
  assign we_flags  = we_i && (addr_i == ADDR_W'(ADDR_FLAGS));
  assign ctrl_wr   = ctrl_t'(wdata_i[CTRL_W-1:0]);
  assign start     = we_ctrl && ctrl_wr.run && !ctrl_q.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      pulse_q  <= 1'b0;
    end else begin
      if (we_ctrl)   ctrl_q   <= ctrl_wr;
      if (we_reload) reload_q <= wdata_i[CNT_W-1:0];
      pulse_q <= period_end;
    end
  end

  cdt_tick_sel #(.N_SRC(N_SRC)) u_sel (
    .tick_i (tick_i),
    .sel_i  (ctrl_q.src),
    .tick_o (sel_tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl_q.run),
    .start_i  (start),
    .tick_i   (sel_tick),
    .reload_i (reload_q),
    .count_o  (count),
    .end_o    (period_end)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_TMR] = period_end;
    flag_set[FLAG_ALM] = alarm_evt_i;
    flag_set[FLAG_MS]  = ms_evt_i;
  end

  cdt_flags #(.N(N_FLAGS)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .wr_i    (we_flags),
    .wdata_i (wdata_i[N_FLAGS-1:0]),
    .flags_o (flags_q)
  );

  assign irq_o = ctrl_q.irq_en && (ctrl_q.pulse_mode ? pulse_q : flags_q[FLAG_TMR]);

  always_comb begin
    case (addr_i)
      ADDR_W'(ADDR_CTRL):   rdata_o = DATA_W'(ctrl_q);
      ADDR_W'(ADDR_RELOAD): rdata_o = DATA_W'(reload_q);
      ADDR_W'(ADDR_COUNT):  rdata_o = DATA_W'(count);
      default:              rdata_o = DATA_W'(flags_q);
    endcase
  end
endmodule

// File: rtl/cd_timer_chk.sv
module cd_timer_chk #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              alarm_evt_i,
  input logic              tf_i,
  input logic              af_i,
  input logic              run_i,
  input logic              period_end_i,
  input logic              pulse_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [CNT_W-1:0]  reload_i
);
  logic clr_tf;
  assign clr_tf = we_i && (addr_i == ADDR_W'(3)) && !wdata_i[0];

  p_tf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_i && !clr_tf |=> tf_i);

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_i |=> count_i == $past(reload_i));

  p_pulse_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |-> tf_i);

  p_af_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !af_i && !alarm_evt_i |=> !af_i);

  p_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(count_i));
endmodule

bind cd_timer cd_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .alarm_evt_i  (alarm_evt_i),
  .tf_i         (flags_q[0]),
  .af_i         (flags_q[1]),
  .run_i        (ctrl_q.run),
  .period_end_i (period_end),
  .pulse_i      (pulse_q),
  .count_i      (count),
  .reload_i     (reload_q)
);

// File: tb/cd_timer_bench.sv
`timescale 1ns/1ps
module cd_timer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] tick_i = '0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       alarm_evt_i = 1'b0;
  logic       ms_evt_i = 1'b0;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cd_timer u_cd_timer (.*);

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    step();
    we_i = 1'b0;
  endtask

  task automatic tick(input int s);
    tick_i[s] = 1'b1;
    step();
    tick_i = '0;
  endtask

  task automatic ticks(input int s, input int n);
    for (int i = 0; i < n; i++) tick(s);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    addr_i = a;
    #1;
    chk(rdata_o, exp, req);
  endtask

  task automatic t_reset();
    chk_rd(2'd0, 8'h00, "R1 ctrl");
    chk_rd(2'd1, 8'h00, "R1 reload");
    chk_rd(2'd2, 8'h00, "R1 count");
    chk_rd(2'd3, 8'h00, "R1 flags");
    chk(irq_o, 1'b0, "R1 irq");
  endtask

  task automatic t_basic();
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h05);               // run, src=1 Hz
    chk_rd(2'd2, 8'd0, "R3 no load before tick");
    tick(2);
    chk_rd(2'd2, 8'd3, "R3 load on first tick");
    tick(0); tick(1); tick(3);
    chk_rd(2'd2, 8'd3, "R2 other sources ignored");
    tick(2);
    chk_rd(2'd2, 8'd2, "R3 decrement");
    tick(2);
    chk_rd(2'd3, 8'h00, "R4 no flag mid-period");
    tick(2);
    chk_rd(2'd3, 8'h01, "R4 flag at period end");
    chk_rd(2'd2, 8'd3, "R3 reload at end");
    step(); step();
    chk_rd(2'd3, 8'h01, "R4 flag sticky");
    wr(2'd3, 8'hFE);
    chk_rd(2'd3, 8'h00, "R5 clear by zero");
  endtask

  task automatic t_source3();
    wr(2'd0, 8'h07);               // run kept, src=1/60 Hz
    tick(2);
    chk_rd(2'd2, 8'd3, "R2 old source ignored");
    tick(3);
    chk_rd(2'd2, 8'd2, "R2 minute source counts");
    chk_rd(2'd2, 8'd2, "R3 no re-arm when run stays 1");
    tick(3); tick(3);
    chk_rd(2'd3, 8'h01, "R2 period on minute source");
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h05);
  endtask

  task automatic t_level();
    wr(2'd0, 8'h0D);               // irq_en, level
    chk(irq_o, 1'b0, "R8 low while flag clear");
    ticks(2, 3);
    chk(irq_o, 1'b1, "R8 follows flag");
    step(); step();
    chk(irq_o, 1'b1, "R8 level held");
    wr(2'd3, 8'hFE);
    chk(irq_o, 1'b0, "R8 drops on clear");
  endtask

  task automatic t_pulse();
    wr(2'd0, 8'h1D);               // irq_en, pulse
    ticks(2, 2);
    chk(irq_o, 1'b0, "R9 no pulse mid-period");
    tick(2);
    chk(irq_o, 1'b1, "R9 pulse at end");
    chk_rd(2'd3, 8'h01, "R9 flag with pulse");
    step();
    chk(irq_o, 1'b0, "R9 single cycle");
    ticks(2, 3);
    chk(irq_o, 1'b1, "R9 pulse with flag already set");
    step();
    chk(irq_o, 1'b0, "R9 second pulse single cycle");
  endtask

  task automatic t_noie();
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h15);               // pulse, irq disabled
    ticks(2, 3);
    chk(irq_o, 1'b0, "R10 no pulse when disabled");
    chk_rd(2'd3, 8'h01, "R10 flag still set");
    wr(2'd0, 8'h05);               // level, disabled
    chk(irq_o, 1'b0, "R10 no level when disabled");
    wr(2'd3, 8'h00);
  endtask

  task automatic t_flags();
    alarm_evt_i = 1'b1; step(); alarm_evt_i = 1'b0;
    chk_rd(2'd3, 8'h02, "R7 alarm flag");
    ms_evt_i = 1'b1; step(); ms_evt_i = 1'b0;
    ticks(2, 3);
    chk_rd(2'd3, 8'h07, "R7 all flags");
    wr(2'd3, 8'hFD);
    chk_rd(2'd3, 8'h05, "R5 clear alarm only");
    wr(2'd3, 8'hFF);
    chk_rd(2'd3, 8'h05, "R5 ones keep flags");
    wr(2'd3, 8'hFB);
    chk_rd(2'd3, 8'h01, "R5 clear ms only");
    wr(2'd3, 8'h00);
    ms_evt_i = 1'b1; step(); ms_evt_i = 1'b0;
    addr_i = 2'd3; wdata_i = 8'h00; we_i = 1'b1; alarm_evt_i = 1'b1;
    step();
    we_i = 1'b0; alarm_evt_i = 1'b0;
    chk_rd(2'd3, 8'h02, "R6 set wins over clear");
    wr(2'd3, 8'h00);
  endtask

  task automatic t_count_ro();
    chk_rd(2'd2, 8'd3, "R11 count before write");
    wr(2'd2, 8'h55);
    chk_rd(2'd2, 8'd3, "R11 write ignored");
    tick(2);
    chk_rd(2'd2, 8'd2, "R11 live count");
  endtask

  task automatic t_reload();
    wr(2'd1, 8'd5);
    tick(2);
    chk_rd(2'd2, 8'd1, "R12 period in progress kept");
    chk_rd(2'd3, 8'h00, "R12 no early end");
    tick(2);
    chk_rd(2'd2, 8'd5, "R12 new value at reload");
    wr(2'd3, 8'h00);
    ticks(2, 4);
    chk_rd(2'd3, 8'h00, "R12 long period mid");
    tick(2);
    chk_rd(2'd3, 8'h01, "R12 long period end");
    wr(2'd3, 8'h00);
  endtask

  task automatic t_stop();
    wr(2'd0, 8'h04);               // run=0
    ticks(2, 7);
    chk_rd(2'd2, 8'd5, "R13 count held");
    chk_rd(2'd3, 8'h00, "R13 no period end");
    wr(2'd1, 8'd2);
    wr(2'd0, 8'h05);
    chk_rd(2'd2, 8'd5, "R3 no load before tick");
    tick(2);
    chk_rd(2'd2, 8'd2, "R3 reload on restart");
    ticks(2, 2);
    chk_rd(2'd3, 8'h01, "R3 restarted period");
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_basic();
    t_source3();
    t_level();
    t_pulse();
    t_noie();
    t_flags();
    t_count_ro();
    t_reload();
    t_stop();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule